// File: doc/BRIEF.md
# Three-Lane Operand Bypass Network

This block supplies the execute-stage operands of a three-lane, four-stage VLIW pipeline whose lanes share a single register file of 16 entries. Each lane brings two source operands into execute, so the block serves six operands. For every operand it compares the source index with the destinations of the results still in flight in all three lanes. These are the results leaving the execute stage and the results sitting in the writeback stage. The block then delivers the newest matching value in place of the register-file contents.

A dependency resolves the same way whether the producer is in the consumer's own lane or in another lane. The block therefore covers every within-lane and cross-lane case without stalling. It also holds the shared register file, which the writeback stage of all three lanes updates on each clock edge. The data width and the register count are parameters.

Top module: `bypass3`

## Requirements
- R1: While `rst_n` is low, every register-file entry is cleared to zero, and writeback writes are ignored. After reset, an operand with no forwarding match reads zero.
- R2: An operand whose source index matches no in-flight result with its write-enable set takes the value of the register-file entry it names.
- R3: A candidate whose write-enable is clear never forwards, even when its destination index equals the source index.
- R4: A matching execute-stage result takes priority over any matching writeback-stage result.
- R5: When several execute-stage lanes match, the value of the highest-numbered lane among them is forwarded.
- R6: When no execute-stage lane matches and several writeback-stage lanes match, the value of the highest-numbered lane among them is forwarded.
- R7: On each rising edge, every writeback lane with its write-enable set writes its register. When lanes name the same register, the highest-numbered lane's data is stored. The stored value is visible from the next cycle and persists until overwritten.
- R8: A writeback in the current cycle is already visible to the operands in that same cycle (write-first behaviour).
- R9: Any lane's result forwards to any of the six operands. Within-lane and cross-lane dependencies follow identical rules, and each operand resolves independently of the others.
- R10: Operand j belongs to lane j/2, slot j%2. It uses `src_idx[j*4 +: 4]` and drives `opnd[j*DATA_W +: DATA_W]`. The per-lane fields of lane l sit at `[l*4 +: 4]` for indices and at `[l*DATA_W +: DATA_W]` for data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the register file |
| src_idx | input | 6*4 | Source register indices of the six execute-stage operands |
| ex_we | input | 3 | Write-enable of the result leaving execute, per lane |
| ex_rd | input | 3*4 | Destination index of the execute result, per lane |
| ex_data | input | 3*DATA_W | Execute result value, per lane |
| wb_we | input | 3 | Write-enable of the writeback-stage result, per lane |
| wb_rd | input | 3*4 | Destination index of the writeback result, per lane |
| wb_data | input | 3*DATA_W | Writeback result value, per lane |
| opnd | output | 6*DATA_W | Resolved operand values for the six execute-stage operands |

## Verification
The operand outputs are purely combinational, so each operand is due in the same cycle as the indices and candidates that produce it. Register-file updates show up only after the next rising edge. The bench drives inputs just after a falling edge and samples the operands a few nanoseconds later, still within that cycle. It folds the writebacks into its model only after the following rising edge. The sweep walks every combination of execute and writeback matches for every operand, and it fills non-matching lanes with wrong-index writers and disabled same-index writers.

// File: rtl/bypass3.sv
module bypass3 #(
  parameter int DATA_W = 64,
  parameter int LANES  = 3,
  parameter int REGS   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2*LANES*$clog2(REGS)-1:0] src_idx,
  input  logic [LANES-1:0]              ex_we,
  input  logic [LANES*$clog2(REGS)-1:0] ex_rd,
  input  logic [LANES*DATA_W-1:0]       ex_data,
  input  logic [LANES-1:0]              wb_we,
  input  logic [LANES*$clog2(REGS)-1:0] wb_rd,
  input  logic [LANES*DATA_W-1:0]       wb_data,
  output logic [2*LANES*DATA_W-1:0]     opnd
);
  localparam int IW  = $clog2(REGS);
  localparam int OPS = 2 * LANES;
  localparam int TOP = LANES - 1;

  logic [DATA_W-1:0] rf [REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < REGS; r++) rf[r] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (wb_we[l]) rf[wb_rd[l*IW +: IW]] <= wb_data[l*DATA_W +: DATA_W];
    end
  end

  logic [LANES-1:0] wb_shadowed;
  always_comb begin
    wb_shadowed = '0;
    for (int l = 0; l < LANES; l++)
      for (int h = l + 1; h < LANES; h++)
        if (wb_we[h] && wb_rd[h*IW +: IW] == wb_rd[l*IW +: IW]) wb_shadowed[l] = 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assert_rf_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we[g] && !wb_shadowed[g]) |=>
          rf[$past(wb_rd[g*IW +: IW])] == $past(wb_data[g*DATA_W +: DATA_W]));
    end

    for (g = 0; g < OPS; g++) begin : g_op
      logic [IW-1:0]     s;
      logic              hx, hw;
      logic [DATA_W-1:0] vx, vw;

      assign s = src_idx[g*IW +: IW];

      always_comb begin
        hx = 1'b0; vx = '0;
        hw = 1'b0; vw = '0;
        for (int l = 0; l < LANES; l++) begin
          if (ex_we[l] && ex_rd[l*IW +: IW] == s) begin
            hx = 1'b1; vx = ex_data[l*DATA_W +: DATA_W];
          end
          if (wb_we[l] && wb_rd[l*IW +: IW] == s) begin
            hw = 1'b1; vw = wb_data[l*DATA_W +: DATA_W];
          end
        end
      end

      assign opnd[g*DATA_W +: DATA_W] = hx ? vx : (hw ? vw : rf[s]);

      assert_ex_top_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_we[TOP] && ex_rd[TOP*IW +: IW] == s) |->
          opnd[g*DATA_W +: DATA_W] == ex_data[TOP*DATA_W +: DATA_W]);

      assert_wb_top_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hx && wb_we[TOP] && wb_rd[TOP*IW +: IW] == s) |->
          opnd[g*DATA_W +: DATA_W] == wb_data[TOP*DATA_W +: DATA_W]);

      assert_ex_over_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hx && hw) |-> opnd[g*DATA_W +: DATA_W] == vx);

      assert_quiet_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hx && !hw && $past(!hx && !hw) && $stable(s) && $past(wb_we) == '0) |->
          $stable(opnd[g*DATA_W +: DATA_W]));
    end
  endgenerate
endmodule

// File: tb/bypass3_tb.sv
module bypass3_tb;
  localparam int W = 16;
  localparam int L = 3;
  localparam int N = 16;
  localparam int OPS = 6;

  logic clk = 0, rst_n = 0;
  logic [OPS*4-1:0] src_idx = '0;
  logic [L-1:0]     ex_we = '0, wb_we = '0;
  logic [L*4-1:0]   ex_rd = '0, wb_rd = '0;
  logic [L*W-1:0]   ex_data = '0, wb_data = '0;
  logic [OPS*W-1:0] opnd;

  bypass3 #(.DATA_W(W), .LANES(L), .REGS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_idx(src_idx),
    .ex_we(ex_we), .ex_rd(ex_rd), .ex_data(ex_data),
    .wb_we(wb_we), .wb_rd(wb_rd), .wb_data(wb_data), .opnd(opnd));

  always #10 clk = ~clk;

  logic [W-1:0] model [N];
  int nvec = 0, nbad = 0;
  bit done = 0;

  function automatic logic [W-1:0] expect_op(int j);
    logic [3:0] s = src_idx[j*4 +: 4];
    logic [W-1:0] v = model[s];
    for (int l = 0; l < L; l++)
      if (wb_we[l] && wb_rd[l*4 +: 4] == s) v = wb_data[l*W +: W];
    for (int l = 0; l < L; l++)
      if (ex_we[l] && ex_rd[l*4 +: 4] == s) v = ex_data[l*W +: W];
    return v;
  endfunction

  task automatic check_all(string req);
    #3;
    for (int j = 0; j < OPS; j++) begin
      logic [W-1:0] e = expect_op(j);
      logic [W-1:0] got = opnd[j*W +: W];
      nvec++;
      if (got !== e) begin
        nbad++;
        $display("FAIL %s operand %0d: got %h expected %h", req, j, got, e);
      end
    end
  endtask

  task automatic commit();
    @(posedge clk);
    if (rst_n)
      for (int l = 0; l < L; l++)
        if (wb_we[l]) model[wb_rd[l*4 +: 4]] = wb_data[l*W +: W];
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < N; r++) model[r] = '0;
    // R1: writes during reset are ignored
    wb_we = 3'b111; wb_rd = {4'd3, 4'd2, 4'd1}; wb_data = {16'hAAAA, 16'hBBBB, 16'hCCCC};
    repeat (3) @(negedge clk);
    wb_we = '0;
    rst_n = 1;
    for (int j = 0; j < OPS; j++) src_idx[j*4 +: 4] = 4'(j * 3);
    check_all("R1 R10");
    for (int j = 0; j < OPS; j++) src_idx[j*4 +: 4] = 4'(j + 1);
    check_all("R1");

    // R7 R8: fill, with lane collisions on every fourth register
    for (int r = 0; r < N; r++) begin
      wb_we = 3'b001;
      wb_rd[0 +: 4] = 4'(r); wb_data[0 +: W] = 16'h1000 + 16'(r);
      if (r % 4 == 0) begin
        wb_we = 3'b111;
        wb_rd[4 +: 4] = 4'(r); wb_data[W +: W] = 16'h3000 + 16'(r);
        wb_rd[8 +: 4] = 4'(r); wb_data[2*W +: W] = 16'h2000 + 16'(r);
      end
      for (int j = 0; j < OPS; j++) src_idx[j*4 +: 4] = (j % 2 == 0) ? 4'(r) : 4'(r + j);
      check_all("R8 R6");
      commit();
    end
    wb_we = '0;

    // R2 R7: read back without forwarding
    for (int r = 0; r < N; r++) begin
      for (int j = 0; j < OPS; j++) src_idx[j*4 +: 4] = 4'(r + j);
      check_all("R2 R7");
      @(negedge clk);
    end

    // R3 R4 R5 R6 R9: every execute/writeback match pattern for each operand
    for (int k = 0; k < OPS; k++) begin
      for (int m = 0; m < 64; m++) begin
        logic [3:0] t = 4'(m * 5 + k);
        for (int j = 0; j < OPS; j++) src_idx[j*4 +: 4] = (j == k) ? t : 4'(t + j);
        for (int l = 0; l < L; l++) begin
          ex_data[l*W +: W] = {4'hE, 4'(l), 8'(nvec)};
          wb_data[l*W +: W] = {4'hB, 4'(l), 8'(nvec + k)};
          if (m[l]) begin ex_we[l] = 1'b1; ex_rd[l*4 +: 4] = t; end
          else if ((m + l) % 2 == 0) begin ex_we[l] = 1'b0; ex_rd[l*4 +: 4] = t; end
          else begin ex_we[l] = 1'b1; ex_rd[l*4 +: 4] = t ^ 4'd1; end
          if (m[3+l]) begin wb_we[l] = 1'b1; wb_rd[l*4 +: 4] = t; end
          else if ((m + l) % 2 == 1) begin wb_we[l] = 1'b0; wb_rd[l*4 +: 4] = t; end
          else begin wb_we[l] = 1'b1; wb_rd[l*4 +: 4] = t ^ 4'd2; end
        end
        check_all("R3 R4 R5 R6 R9");
        commit();
      end
    end
    ex_we = '0; wb_we = '0;

    // R7: final state after the sweep's writebacks
    for (int r = 0; r < N; r++) begin
      for (int j = 0; j < OPS; j++) src_idx[j*4 +: 4] = 4'(r + 2 * j);
      check_all("R7 R2");
      @(negedge clk);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule